// File: doc/BRIEF.md
# Triangular Spread-Spectrum Dither Generator

This block makes the dither term for a fractional-N feedback divider. It runs on the reference clock and, once per reference cycle, moves a signed offset up or down by a programmed step. The offset traces a symmetric triangle centred on zero: it climbs to a positive peak, returns to zero, falls to a negative peak and comes back. Each of these four legs lasts the programmed quarter-period, so one sweep takes four times that count in reference cycles. The modulation rate therefore tracks the reference frequency.

Software writes one 32-bit configuration word. The word holds a 13-bit quarter-period count and a 16-bit step size, and both reset to zero. The offset is in units of 1/256 of a divider step. The block also outputs the nominal integer divider, extended with an 8-bit fraction, with the offset added and the result clamped to the representable range.

A new word is held in a shadow register. It becomes active only when the sweep is back at zero offset at the end of a full cycle, or at once while the generator is idle. This keeps the average offset free of any DC shift. The controller has five states: `ST_IDLE` (offset held at zero), `ST_RISE_A` (zero to positive peak), `ST_FALL_A` (positive peak to zero), `ST_FALL_B` (zero to negative peak) and `ST_RISE_B` (negative peak back to zero). Its transitions are:
- `IDLE->RISE_A`: both shadow fields are non-zero.
- `RISE_A->FALL_A`, `FALL_A->FALL_B`, `FALL_B->RISE_B`: the leg counter reaches the quarter-period.
- `RISE_B->RISE_A` (wrap): the leg ends and the shadow is non-zero.
- `RISE_B->IDLE` (stop): the leg ends and a shadow field is zero.

Top module: `ssc_tri_gen`

## Requirements
- R1: The configuration word holds the quarter-period count in bits [28:16] and the step size in bits [15:0]. A read returns the last written fields, and bits [31:29] always read as zero whatever was written.
- R2: After reset, the configuration reads zero, the offset is zero and the divider output equals the nominal value times 256.
- R3: While either field of the active configuration is zero, the offset stays at zero.
- R4: A write made while idle and with both fields non-zero starts the sweep. The offset is still zero after the write edge and after the next edge. From the following edge it grows by the step on every edge and reaches step × period after period rising steps.
- R5: The offset then falls by the step on each edge and reaches zero after period more edges. It returns to zero exactly at the end of the fourth leg, 4 × period edges after the sweep started, and the next sweep follows with no gap.
- R6: The negative peak, reached at the end of the third leg, equals minus step × period.
- R7: A configuration write made during a sweep changes nothing until that sweep ends at zero offset. From the next edge the new values apply, and a zero field stops the generator.
- R8: The divider output equals nominal × 256 plus the offset.
- R9: The divider output clamps to zero when that sum is negative, and to all ones when the sum exceeds the output width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data (shadow register) |
| div_nom | input | INT_W (8) | Nominal integer divider value |
| offset_o | output | OFS_W (30) | Signed dither offset, 1/256 divider-step units |
| div_o | output | INT_W+FRAC_W (16) | Nominal divider with fraction, plus offset, clamped |

## Verification
The bench compares every cycle of a sweep against a triangle built from the requirements. A design whose leg counter is off by one would shift every peak and leave a non-zero residue at the wrap point. A design that applied a new configuration in the middle of a sweep would bend the triangle before the zero crossing. A design that stopped at once on a zero write would cut the sweep short. The scenarios also start from idle and run back-to-back sweeps, where a design that inserts an idle cycle between sweeps is caught. Nominal divider values near both ends of the range check the clamp, which a design that wraps would fail with a large jump in the output.

// File: rtl/ssc_pkg.sv
package ssc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_RISE_A = 3'd1,
        ST_FALL_A = 3'd2,
        ST_FALL_B = 3'd3,
        ST_RISE_B = 3'd4
    } ssc_state_e;

    // bit position of the quarter-period field inside the configuration word
    localparam int CFG_PER_LSB = 16;

endpackage

// File: rtl/ssc_cfg_reg.sv
module ssc_cfg_reg #(
    parameter int PER_W   = 13,
    parameter int SLP_W   = 16,
    parameter int PER_LSB = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic [PER_W-1:0] shd_per,
    output logic [SLP_W-1:0] shd_slp
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_per <= '0;
            shd_slp <= '0;
        end else if (we) begin
            shd_per <= wdata[PER_LSB +: PER_W];
            shd_slp <= wdata[SLP_W-1:0];
        end
    end

    always_comb begin
        rdata                    = '0;
        rdata[PER_LSB +: PER_W]  = shd_per;
        rdata[SLP_W-1:0]         = shd_slp;
    end

endmodule

// File: rtl/ssc_phase_fsm.sv
module ssc_phase_fsm
    import ssc_pkg::*;
#(
    parameter int PER_W = 13,
    parameter int SLP_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PER_W-1:0] shd_per,
    input  logic [SLP_W-1:0] shd_slp,
    output ssc_state_e       state,
    output logic [PER_W-1:0] phase_cnt,
    output logic [PER_W-1:0] act_per,
    output logic [SLP_W-1:0] act_slp,
    output logic             step_en,
    output logic             step_dn
);

    ssc_state_e state_nxt;
    logic       leg_end;
    logic       shd_valid;
    logic       load_act;

    assign leg_end   = (phase_cnt == act_per - PER_W'(1));
    assign shd_valid = (shd_per != '0) && (shd_slp != '0);

    // next-state decision
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:   if (shd_valid) state_nxt = ST_RISE_A;
            ST_RISE_A: if (leg_end)   state_nxt = ST_FALL_A;
            ST_FALL_A: if (leg_end)   state_nxt = ST_FALL_B;
            ST_FALL_B: if (leg_end)   state_nxt = ST_RISE_B;
            ST_RISE_B: if (leg_end)   state_nxt = shd_valid ? ST_RISE_A : ST_IDLE;
            default:                  state_nxt = ST_IDLE;
        endcase
    end

    // state register, leg counter and active configuration
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            phase_cnt <= '0;
            act_per   <= '0;
            act_slp   <= '0;
        end else begin
            state <= state_nxt;
            if (state == ST_IDLE || leg_end) phase_cnt <= '0;
            else                             phase_cnt <= phase_cnt + PER_W'(1);
            if (load_act) begin
                act_per <= shd_per;
                act_slp <= shd_slp;
            end
        end
    end

    // per-state outputs
    always_comb begin
        step_en  = 1'b0;
        step_dn  = 1'b0;
        load_act = 1'b0;
        unique case (state)
            ST_IDLE:   load_act = 1'b1;
            ST_RISE_A: step_en  = 1'b1;
            ST_FALL_A: begin step_en = 1'b1; step_dn = 1'b1; end
            ST_FALL_B: begin step_en = 1'b1; step_dn = 1'b1; end
            ST_RISE_B: begin step_en = 1'b1; load_act = leg_end; end
            default:   load_act = 1'b0;
        endcase
    end

endmodule

// File: rtl/ssc_accum.sv
module ssc_accum #(
    parameter int SLP_W = 16,
    parameter int OFS_W = 30
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_en,
    input  logic                    step_dn,
    input  logic [SLP_W-1:0]        slope,
    output logic signed [OFS_W-1:0] acc
);

    logic signed [OFS_W-1:0] slp_ext;

    assign slp_ext = $signed({{(OFS_W-SLP_W){1'b0}}, slope});

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       acc <= '0;
        else if (!step_en) acc <= '0;
        else if (step_dn) acc <= acc - slp_ext;
        else              acc <= acc + slp_ext;
    end

endmodule

// File: rtl/ssc_div_sat.sv
module ssc_div_sat #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 8,
    parameter int OFS_W  = 30
) (
    input  logic [INT_W-1:0]        nom,
    input  logic signed [OFS_W-1:0] ofs,
    output logic [INT_W+FRAC_W-1:0] div
);

    localparam int DIV_W = INT_W + FRAC_W;
    localparam int SUM_W = ((OFS_W > DIV_W) ? OFS_W : DIV_W) + 2;

    logic signed [SUM_W-1:0] base;
    logic signed [SUM_W-1:0] ext;
    logic signed [SUM_W-1:0] sum;

    assign base = $signed({{(SUM_W-DIV_W){1'b0}}, nom, {FRAC_W{1'b0}}});
    assign ext  = $signed({{(SUM_W-OFS_W){ofs[OFS_W-1]}}, ofs});
    assign sum  = base + ext;

    always_comb begin
        if (sum[SUM_W-1])                 div = '0;
        else if (|sum[SUM_W-2:DIV_W])     div = '1;
        else                              div = sum[DIV_W-1:0];
    end

endmodule

// File: rtl/ssc_tri_gen.sv
module ssc_tri_gen
    import ssc_pkg::*;
#(
    parameter int PER_W  = 13,
    parameter int SLP_W  = 16,
    parameter int INT_W  = 8,
    parameter int FRAC_W = 8,
    parameter int OFS_W  = PER_W + SLP_W + 1,
    parameter int DIV_W  = INT_W + FRAC_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [31:0]             cfg_wdata,
    output logic [31:0]             cfg_rdata,
    input  logic [INT_W-1:0]        div_nom,
    output logic signed [OFS_W-1:0] offset_o,
    output logic [DIV_W-1:0]        div_o
);

    logic [PER_W-1:0] shd_per;
    logic [SLP_W-1:0] shd_slp;
    logic [PER_W-1:0] act_per;
    logic [SLP_W-1:0] act_slp;
    logic [PER_W-1:0] phase_cnt;
    logic             step_en;
    logic             step_dn;
    ssc_state_e       state;

    ssc_cfg_reg #(
        .PER_W   (PER_W),
        .SLP_W   (SLP_W),
        .PER_LSB (CFG_PER_LSB)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (cfg_we),
        .wdata   (cfg_wdata),
        .rdata   (cfg_rdata),
        .shd_per (shd_per),
        .shd_slp (shd_slp)
    );

    ssc_phase_fsm #(
        .PER_W (PER_W),
        .SLP_W (SLP_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .shd_per   (shd_per),
        .shd_slp   (shd_slp),
        .state     (state),
        .phase_cnt (phase_cnt),
        .act_per   (act_per),
        .act_slp   (act_slp),
        .step_en   (step_en),
        .step_dn   (step_dn)
    );

    ssc_accum #(
        .SLP_W (SLP_W),
        .OFS_W (OFS_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .step_en (step_en),
        .step_dn (step_dn),
        .slope   (act_slp),
        .acc     (offset_o)
    );

    ssc_div_sat #(
        .INT_W  (INT_W),
        .FRAC_W (FRAC_W),
        .OFS_W  (OFS_W)
    ) u_sat (
        .nom (div_nom),
        .ofs (offset_o),
        .div (div_o)
    );

endmodule

// File: rtl/ssc_tri_chk.sv
module ssc_tri_chk
    import ssc_pkg::*;
#(
    parameter int PER_W = 13,
    parameter int SLP_W = 16,
    parameter int OFS_W = 30
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [31:0]             cfg_rdata,
    input logic signed [OFS_W-1:0] offset_o,
    input ssc_state_e              state,
    input logic [PER_W-1:0]        phase_cnt,
    input logic [PER_W-1:0]        act_per,
    input logic [SLP_W-1:0]        act_slp
);

    logic signed [OFS_W-1:0] slp_ext;
    logic signed [OFS_W-1:0] peak_val;
    logic                    last_cnt;

    assign slp_ext  = $signed({{(OFS_W-SLP_W){1'b0}}, act_slp});
    assign peak_val = $signed({{(OFS_W-SLP_W){1'b0}}, act_slp} * {{(OFS_W-PER_W){1'b0}}, act_per});
    assign last_cnt = (phase_cnt == act_per - PER_W'(1));

    AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_rdata[31:29] == 3'b000);  // R1

    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE) |-> (offset_o == '0));  // R3

    AST_STEP_SIZE: assert property (@(posedge clk) disable iff (!rst_n)
        (offset_o == $past(offset_o)) ||
        (offset_o == $past(offset_o) + $past(slp_ext)) ||
        (offset_o == $past(offset_o) - $past(slp_ext)));  // R4

    AST_POS_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RISE_A && last_cnt) |=> (offset_o == peak_val));  // R4

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RISE_B && last_cnt) |=> (offset_o == '0));  // R5

    AST_NEG_PEAK: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FALL_B && last_cnt) |=> (offset_o == -peak_val));  // R6

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_IDLE && !(state == ST_RISE_B && last_cnt)) |=>
        ($stable(act_per) && $stable(act_slp)));  // R7

endmodule

bind ssc_tri_gen ssc_tri_chk #(
    .PER_W (PER_W),
    .SLP_W (SLP_W),
    .OFS_W (OFS_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_rdata (cfg_rdata),
    .offset_o  (offset_o),
    .state     (state),
    .phase_cnt (phase_cnt),
    .act_per   (act_per),
    .act_slp   (act_slp)
);

// File: tb/ssc_tri_gen_tb.sv
`timescale 1ns/1ps
module ssc_tri_gen_tb;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               cfg_we;
    logic [31:0]        cfg_wdata;
    logic [31:0]        cfg_rdata;
    logic [7:0]         div_nom;
    logic signed [29:0] offset_o;
    logic [15:0]        div_o;

    int n_chk  = 0;
    int n_fail = 0;
    int nom    = 100;
    bit done   = 1'b0;

    typedef struct {
        int    off;
        int    dv;
        string tag;
        string dtag;
    } exp_t;

    exp_t q[$];

    always #5 clk = ~clk;

    ssc_tri_gen u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .div_nom   (div_nom),
        .offset_o  (offset_o),
        .div_o     (div_o)
    );

    function automatic int sat16(int v);
        if (v < 0)     return 0;
        if (v > 65535) return 65535;
        return v;
    endfunction

    function automatic logic [31:0] cfg_word(int per, int slp);
        return {3'b000, 13'(per), 16'(slp)};
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic push(int off, string tag);
        exp_t e;
        int   raw;
        raw    = nom * 256 + off;
        e.off  = off;
        e.dv   = sat16(raw);
        e.tag  = tag;
        e.dtag = (raw < 0 || raw > 65535) ? "R9" : "R8";
        q.push_back(e);
    endtask

    // one full sweep; an empty tag uses the requirement of each leg
    task automatic push_tri(int p, int s, string t);
        for (int i = 1; i <= p; i++) push(i * s,        (t == "") ? "R4" : t);
        for (int i = 1; i <= p; i++) push((p - i) * s,  (t == "") ? "R5" : t);
        for (int i = 1; i <= p; i++) push(-i * s,       (t == "") ? "R6" : t);
        for (int i = 1; i <= p; i++) push(-(p - i) * s, (t == "") ? "R5" : t);
    endtask

    task automatic wr_start(logic [31:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
    endtask

    task automatic wr_end();
        @(negedge clk);
        cfg_we    = 1'b0;
        cfg_wdata = '0;
    endtask

    task automatic drain();
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic set_nom(int n);
        nom     = n;
        div_nom = 8'(n);
    endtask

    // monitor: pops one expected item per cycle, shortly after the edge
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                e = q.pop_front();
                check(int'(offset_o) == e.off, e.tag, "offset", int'(offset_o), e.off);
                check(int'(div_o) == e.dv, e.dtag, "divider", int'(div_o), e.dv);
            end
        end
    end

    // watchdog
    initial begin
        #1_000_000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // driver
    initial begin
        rst_n     = 1'b0;
        cfg_we    = 1'b0;
        cfg_wdata = '0;
        set_nom(100);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R2: reset state
        check(cfg_rdata == 32'h0, "R2", "cfg read", int'(cfg_rdata), 0);
        check(offset_o == '0, "R2", "offset", int'(offset_o), 0);
        check(div_o == 16'd25600, "R2", "divider", int'(div_o), 25600);

        // R3 and R1: zero period with reserved bits set, offset must stay zero
        wr_start(32'hE000_0005);
        for (int i = 0; i < 12; i++) push(0, "R3");
        wr_end();
        check(cfg_rdata == 32'h0000_0005, "R1", "reserved bits", int'(cfg_rdata), 5);
        drain();

        // R1: field placement on read
        wr_start(32'hFFFF_0000);
        wr_end();
        check(cfg_rdata == 32'h1FFF_0000, "R1", "period field", int'(cfg_rdata), 32'h1FFF_0000);
        wr_start(32'h0);
        for (int i = 0; i < 4; i++) push(0, "R3");
        wr_end();
        drain();

        // R4/R5/R6: two back-to-back sweeps, period 3, step 7, then stop
        wr_start(cfg_word(3, 7));
        push(0, "R4");
        push(0, "R4");
        push_tri(3, 7, "");
        push_tri(3, 7, "R5");
        for (int i = 0; i < 4; i++) push(0, "R7");
        wr_end();
        repeat (14) @(negedge clk);
        wr_start(32'h0);
        wr_end();
        check(cfg_rdata == 32'h0, "R1", "cleared read", int'(cfg_rdata), 0);
        drain();

        // R7: reconfigure mid-sweep, then disable mid-sweep
        wr_start(cfg_word(4, 3));
        push(0, "R4");
        push(0, "R4");
        push_tri(4, 3, "R7");
        push_tri(2, 10, "R7");
        for (int i = 0; i < 4; i++) push(0, "R7");
        wr_end();
        repeat (4) @(negedge clk);
        wr_start(cfg_word(2, 10));
        wr_end();
        repeat (12) @(negedge clk);
        wr_start(32'h0);
        wr_end();
        drain();

        // R9: clamp at zero with a small nominal divider
        set_nom(1);
        @(negedge clk);
        wr_start(cfg_word(4, 100));
        push(0, "R4");
        push(0, "R4");
        push_tri(4, 100, "");
        for (int i = 0; i < 3; i++) push(0, "R7");
        wr_end();
        repeat (5) @(negedge clk);
        wr_start(32'h0);
        wr_end();
        drain();

        // R9: clamp at all ones with a large nominal divider
        set_nom(255);
        @(negedge clk);
        wr_start(cfg_word(4, 100));
        push(0, "R4");
        push(0, "R4");
        push_tri(4, 100, "");
        for (int i = 0; i < 3; i++) push(0, "R7");
        wr_end();
        repeat (5) @(negedge clk);
        wr_start(32'h0);
        wr_end();
        drain();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule